// File: doc/BRIEF.md
# Memory Clock-Enable Power State Sequencer

This block sits on the controller side of a DDR2-style memory interface. It owns the clock-enable pin and the command slot that goes with it, and it moves the memory between normal operation, active power-down, precharge power-down and self refresh. The host asks for power-down, self refresh or exit with level requests. The host also reports whether any bank is open and whether a read, write, mode-register or precharge operation is still in progress. The sequencer decides on each clock edge whether a CKE transition is legal, and it places the matching command (NOP, DESELECT or REFRESH) on the bus at that edge.

When the device is in normal operation and no transition is pending, the command output shows the pass-through code, which lets the host's own command reach the bus. After a self-refresh exit, two countdown timers gate the host. The first blocks all commands for a configurable non-read interval. The second blocks reads for a longer interval, 200 clocks by default.

An external refresh timer can pull the device out of power-down with a force-exit input, because power-down performs no refresh. Requests that are not legal in the current state are dropped, and they set a sticky flag.

Top module: `cke_pwr_seq`

## Requirements
- R1: While reset is applied and until `init_done` is seen high in the init state (`pwr_state`=0), `cke` is 0, `cmd_out` is NOP and both ready flags are 0. The edge that samples `init_done`=1 raises `cke` and moves the block to normal (`pwr_state`=1).
- R2: In normal state with command release, the dwell time met, and `busy`=0, `req_pd`=1 with `bank_open`=1 lowers `cke` with NOP on the bus and enters active power-down (`pwr_state`=2).
- R3: The same entry with `bank_open`=0 enters precharge power-down (`pwr_state`=3).
- R4: `req_sr`=1 with `bank_open`=0 lowers `cke` with REFRESH on the bus and enters self refresh (`pwr_state`=4). REFRESH appears only on such an entry edge.
- R5: While `busy`=1, a pending entry request is held: `cke` stays high and the state stays normal. The entry is taken on the first edge with `busy`=0.
- R6: After any CKE change that follows init, `cke` keeps its new level for at least MIN_DWELL (default 3) cycles before it changes again, in both directions.
- R7: Every exit edge raises `cke` with NOP on the bus. The bus carries DESELECT while the device stays in a low-power state.
- R8: After a self-refresh exit, `cmd_ready` is 0 and `cmd_out` is NOP for T_XSNR (default 10) cycles. After that, `cmd_ready` is 1 and `cmd_out` shows pass-through.
- R9: After a self-refresh exit, `rd_ready` stays 0 for T_XSRD (default 200) cycles. After a power-down exit it is 1 on the cycle right after the exit edge.
- R10: `force_exit` leaves either power-down state like `req_exit`, but it has no effect in self refresh.
- R11: An illegal request sets `illegal_req`, which stays set until reset. The request has no effect on `cke` or state. Illegal requests are: `req_exit` in normal state, `req_sr` with `bank_open`=1, `req_sr` together with `req_pd`, and any entry request while in a low-power state.
- Encodings: `cmd_out` 0=DESELECT, 1=NOP, 2=REFRESH, 3=pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Device initialisation finished |
| req_pd | input | 1 | Power-down entry request (level) |
| req_sr | input | 1 | Self-refresh entry request (level) |
| req_exit | input | 1 | Exit request from any low-power state |
| force_exit | input | 1 | Refresh-deadline exit from power-down |
| bank_open | input | 1 | At least one bank is active |
| busy | input | 1 | Read, write, mode-register or precharge in progress |
| cke | output | 1 | Clock-enable pin drive |
| cmd_out | output | 2 | Registered command code |
| pwr_state | output | 3 | 0 init, 1 normal, 2 active PD, 3 precharge PD, 4 self refresh |
| cmd_ready | output | 1 | Host commands may resume |
| rd_ready | output | 1 | Host reads may resume |
| illegal_req | output | 1 | Sticky illegal-request flag |

## Verification
Two things can happen on the same edge: an illegal request and a legal one, or the dwell limit and a transition request. For example, `req_exit` can arrive together with `req_pd` while the device is in power-down, and a request can arrive on the edge just after CKE moved. The bench provokes this with directed cases that raise the request on the very cycle CKE changes, and with random traffic where several request lines are often high at once. A per-cycle bench model works out each outcome from the requirements: illegal requests block the whole edge, and dwell-blocked requests wait. The bench then compares `cke`, state, command, ready flags and flag against that model.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;

    typedef enum logic [2:0] {
        PS_INIT = 3'd0,
        PS_NORM = 3'd1,
        PS_APD  = 3'd2,
        PS_PPD  = 3'd3,
        PS_SREF = 3'd4
    } pwr_state_e;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_NOP   = 2'd1,
        CMD_REF   = 2'd2,
        CMD_PASS  = 2'd3
    } bus_cmd_e;

    typedef struct packed {
        logic pd;
        logic sr;
        logic ex;
        logic fx;
    } pwr_req_t;

    function automatic logic req_bad_in_norm(pwr_req_t r, logic bank_open);
        return r.ex | (r.sr & (bank_open | r.pd));
    endfunction

    function automatic logic req_bad_in_low(pwr_req_t r);
        return r.pd | r.sr;
    endfunction

endpackage

// File: rtl/cke_dwell_ctr.sv
module cke_dwell_ctr #(
    parameter int MIN_DWELL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic level_change,
    output logic dwell_ok
);
    localparam int W = (MIN_DWELL < 2) ? 1 : $clog2(MIN_DWELL);
    localparam logic [W-1:0] LAST = W'(MIN_DWELL - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || level_change) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dwell_ok = (cnt_q == LAST);
endmodule

// File: rtl/exit_countdown.sv
module exit_countdown #(
    parameter int LOAD = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic is_zero,
    output logic at_most_one
);
    localparam int W = $clog2(LOAD + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= W'(LOAD);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_zero     = (cnt_q == '0);
    assign at_most_one = (cnt_q <= W'(1));
endmodule

// File: rtl/cke_pwr_fsm.sv
module cke_pwr_fsm
    import cke_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init_done,
    input  pwr_req_t   req,
    input  logic       bank_open,
    input  logic       busy,
    input  logic       dwell_ok,
    input  logic       nr_zero,
    input  logic       nr_le1,
    output logic       cke_q,
    output logic       cke_d,
    output bus_cmd_e   cmd_q,
    output pwr_state_e st_q,
    output logic       ill_q,
    output logic       sr_exit
);
    pwr_state_e st_d;
    bus_cmd_e   cmd_d;
    logic       ill_d;

    always_comb begin
        st_d    = st_q;
        cke_d   = cke_q;
        cmd_d   = cmd_q;
        ill_d   = ill_q;
        sr_exit = 1'b0;
        case (st_q)
            PS_INIT: begin
                cmd_d = CMD_NOP;
                if (init_done) begin
                    cke_d = 1'b1;
                    st_d  = PS_NORM;
                end
            end
            PS_NORM: begin
                cmd_d = nr_le1 ? CMD_PASS : CMD_NOP;
                if (req_bad_in_norm(req, bank_open)) begin
                    ill_d = 1'b1;
                end else if (dwell_ok && nr_zero && !busy && (req.pd || req.sr)) begin
                    cke_d = 1'b0;
                    if (req.sr) begin
                        st_d  = PS_SREF;
                        cmd_d = CMD_REF;
                    end else begin
                        st_d  = bank_open ? PS_APD : PS_PPD;
                        cmd_d = CMD_NOP;
                    end
                end
            end
            PS_APD, PS_PPD, PS_SREF: begin
                cmd_d = CMD_DESEL;
                if (req_bad_in_low(req)) begin
                    ill_d = 1'b1;
                end else if (dwell_ok && (req.ex || (req.fx && st_q != PS_SREF))) begin
                    cke_d   = 1'b1;
                    st_d    = PS_NORM;
                    cmd_d   = CMD_NOP;
                    sr_exit = (st_q == PS_SREF);
                end
            end
            default: begin
                st_d  = PS_INIT;
                cke_d = 1'b0;
                cmd_d = CMD_NOP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_INIT;
            cke_q <= 1'b0;
            cmd_q <= CMD_NOP;
            ill_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cke_q <= cke_d;
            cmd_q <= cmd_d;
            ill_q <= ill_d;
        end
    end
endmodule

// File: rtl/cke_pwr_seq.sv
module cke_pwr_seq
    import cke_seq_pkg::*;
#(
    parameter int MIN_DWELL = 3,
    parameter int T_XSNR    = 10,
    parameter int T_XSRD    = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       init_done,
    input  logic       req_pd,
    input  logic       req_sr,
    input  logic       req_exit,
    input  logic       force_exit,
    input  logic       bank_open,
    input  logic       busy,
    output logic       cke,
    output logic [1:0] cmd_out,
    output logic [2:0] pwr_state,
    output logic       cmd_ready,
    output logic       rd_ready,
    output logic       illegal_req
);
    localparam int NUM_TMR = 2;
    localparam int TMR_NR  = 0;
    localparam int TMR_RD  = 1;

    pwr_req_t   req;
    logic       cke_q, cke_d, dwell_ok, ill_q, sr_exit;
    bus_cmd_e   cmd_q;
    pwr_state_e st_q;
    logic [NUM_TMR-1:0] tmr_zero, tmr_le1;

    assign req = '{pd: req_pd, sr: req_sr, ex: req_exit, fx: force_exit};

    cke_dwell_ctr #(.MIN_DWELL(MIN_DWELL)) dwell_i (
        .clk          (clk),
        .rst          (rst),
        .level_change (cke_d != cke_q),
        .dwell_ok     (dwell_ok)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        localparam int LD = (g == TMR_NR) ? T_XSNR : T_XSRD;
        exit_countdown #(.LOAD(LD)) tmr_i (
            .clk         (clk),
            .rst         (rst),
            .load        (sr_exit),
            .is_zero     (tmr_zero[g]),
            .at_most_one (tmr_le1[g])
        );
    end

    cke_pwr_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .init_done (init_done),
        .req       (req),
        .bank_open (bank_open),
        .busy      (busy),
        .dwell_ok  (dwell_ok),
        .nr_zero   (tmr_zero[TMR_NR]),
        .nr_le1    (tmr_le1[TMR_NR]),
        .cke_q     (cke_q),
        .cke_d     (cke_d),
        .cmd_q     (cmd_q),
        .st_q      (st_q),
        .ill_q     (ill_q),
        .sr_exit   (sr_exit)
    );

    assign cke         = cke_q;
    assign cmd_out     = cmd_q;
    assign pwr_state   = st_q;
    assign illegal_req = ill_q;
    assign cmd_ready   = (st_q == PS_NORM) && tmr_zero[TMR_NR];
    assign rd_ready    = (st_q == PS_NORM) && tmr_zero[TMR_RD];
endmodule

// File: rtl/cke_pwr_seq_chk.sv
module cke_pwr_seq_chk #(
    parameter int MIN_DWELL = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic [1:0] cmd_out,
    input logic [2:0] pwr_state,
    input logic       cmd_ready,
    input logic       rd_ready,
    input logic       illegal_req,
    input logic       bank_open
);
    localparam int RW = $clog2(MIN_DWELL + 1) + 1;

    logic          armed, prv_cke, prv_bank;
    logic [2:0]    prv_st;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            prv_cke  <= 1'b0;
            prv_bank <= 1'b0;
            prv_st   <= 3'd0;
            run      <= '0;
        end else begin
            armed    <= 1'b1;
            prv_cke  <= cke;
            prv_bank <= bank_open;
            prv_st   <= pwr_state;
            if (cke != prv_cke) run <= RW'(1);
            else if (run < RW'(MIN_DWELL)) run <= run + 1'b1;
        end
    end

    // R1
    init_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd0) |-> (!cke && !cmd_ready && !rd_ready));

    // R6
    dwell_min_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ((cke != prv_cke) && (prv_st != 3'd0)) |-> (run >= RW'(MIN_DWELL)));

    // R7
    exit_nop_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (cke && !prv_cke && prv_st != 3'd0) |-> (cmd_out == 2'd1));

    // R4
    refresh_idle_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (cmd_out == 2'd2) |-> (pwr_state == 3'd4 && !cke && !prv_bank && prv_st == 3'd1));

    // R8
    no_pass_unready_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> (cmd_out != 2'd3));

    // R9
    read_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> cmd_ready);

    // R11
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_req |=> illegal_req);
endmodule

bind cke_pwr_seq cke_pwr_seq_chk #(.MIN_DWELL(MIN_DWELL)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cke         (cke),
    .cmd_out     (cmd_out),
    .pwr_state   (pwr_state),
    .cmd_ready   (cmd_ready),
    .rd_ready    (rd_ready),
    .illegal_req (illegal_req),
    .bank_open   (bank_open)
);

// File: tb/cke_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module cke_pwr_seq_tb_top;
    localparam int MIN_DWELL = 3;
    localparam int T_XSNR    = 10;
    localparam int T_XSRD    = 200;
    localparam real PERIOD   = 20.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_done = 1'b0, req_pd = 1'b0, req_sr = 1'b0, req_exit = 1'b0;
    logic force_exit = 1'b0, bank_open = 1'b0, busy = 1'b0;
    logic cke, cmd_ready, rd_ready, illegal_req;
    logic [1:0] cmd_out;
    logic [2:0] pwr_state;

    int total = 0;
    int bad = 0;

    int m_st = 0, m_cmd = 1, m_dw = 0, m_xs = 0, m_rd = 0;
    bit m_cke = 0, m_ill = 0;

    always #(PERIOD / 2.0) clk = ~clk;

    cke_pwr_seq #(.MIN_DWELL(MIN_DWELL), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) dut_i (
        .clk(clk), .rst(rst), .init_done(init_done), .req_pd(req_pd), .req_sr(req_sr),
        .req_exit(req_exit), .force_exit(force_exit), .bank_open(bank_open), .busy(busy),
        .cke(cke), .cmd_out(cmd_out), .pwr_state(pwr_state), .cmd_ready(cmd_ready),
        .rd_ready(rd_ready), .illegal_req(illegal_req)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_rdy();
        return (m_st == 1) && (m_xs == 0);
    endfunction

    function automatic bit exp_rd();
        return (m_st == 1) && (m_rd == 0);
    endfunction

    task automatic model_step();
        int n_st = m_st, n_cmd = m_cmd;
        bit n_cke = m_cke, n_ill = m_ill, srx = 0;
        bit okd = (m_dw >= MIN_DWELL - 1);
        if (rst) begin
            m_st = 0; m_cke = 0; m_cmd = 1; m_ill = 0; m_dw = 0; m_xs = 0; m_rd = 0;
            return;
        end
        case (m_st)
            0: begin
                n_cmd = 1;
                if (init_done) begin n_cke = 1; n_st = 1; end
            end
            1: begin
                n_cmd = (m_xs <= 1) ? 3 : 1;
                if (req_exit || (req_sr && (bank_open || req_pd))) n_ill = 1;
                else if (okd && m_xs == 0 && !busy && (req_pd || req_sr)) begin
                    n_cke = 0;
                    if (req_sr) begin n_st = 4; n_cmd = 2; end
                    else begin n_st = bank_open ? 2 : 3; n_cmd = 1; end
                end
            end
            default: begin
                n_cmd = 0;
                if (req_pd || req_sr) n_ill = 1;
                else if (okd && (req_exit || (force_exit && m_st != 4))) begin
                    n_cke = 1; n_st = 1; n_cmd = 1; srx = (m_st == 4);
                end
            end
        endcase
        m_dw  = (n_cke != m_cke) ? 0 : ((m_dw < MIN_DWELL - 1) ? m_dw + 1 : m_dw);
        m_xs  = srx ? T_XSNR : ((m_xs > 0) ? m_xs - 1 : 0);
        m_rd  = srx ? T_XSRD : ((m_rd > 0) ? m_rd - 1 : 0);
        m_st  = n_st; m_cke = n_cke; m_cmd = n_cmd; m_ill = n_ill;
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        total++;
        if (cke !== m_cke || int'(pwr_state) != m_st || int'(cmd_out) != m_cmd ||
            cmd_ready !== exp_rdy() || rd_ready !== exp_rd() || illegal_req !== m_ill) begin
            bad++;
            $display("FAIL %s model: cke=%0b/%0b st=%0d/%0d cmd=%0d/%0d rdy=%0b/%0b rd=%0b/%0b ill=%0b/%0b",
                     tag, cke, m_cke, pwr_state, m_st, cmd_out, m_cmd,
                     cmd_ready, exp_rdy(), rd_ready, exp_rd(), illegal_req, m_ill);
        end
    endtask

    task automatic clear_reqs();
        req_pd = 0; req_sr = 0; req_exit = 0; force_exit = 0; busy = 0;
    endtask

    task automatic do_reset();
        rst = 1; init_done = 0; clear_reqs();
        tick("R1");
        tick("R1");
        rst = 0;
        init_done = 1;
        tick("R1");
        init_done = 0;
    endtask

    initial begin
        #(PERIOD * 200000.0);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        @(negedge clk);
        tick("R1");
        tick("R1");
        rst = 0;
        // R1: no init_done, stays low
        for (int i = 0; i < 5; i++) tick("R1");
        check(cke == 0 && cmd_out == 2'd1 && pwr_state == 3'd0 && !cmd_ready && !rd_ready,
              "R1 init hold", int'(cke), 0);
        init_done = 1;
        tick("R1");
        init_done = 0;
        check(cke == 1 && pwr_state == 3'd1, "R1 init release", int'(pwr_state), 1);

        // R2 and R6: entry request right after CKE rose, dwell gates it
        bank_open = 1; req_pd = 1; n = 0;
        do begin tick("R6"); n++; end while (cke && n < 10);
        req_pd = 0;
        check(n == MIN_DWELL, "R6 high dwell", n, MIN_DWELL);
        check(pwr_state == 3'd2 && cmd_out == 2'd1, "R2 active pd", int'(pwr_state), 2);
        tick("R7");
        check(cmd_out == 2'd0, "R7 deselect while low", int'(cmd_out), 0);

        // R6, R7, R9: exit requested at once
        req_exit = 1; n = 1;
        do begin tick("R6"); n++; end while (!cke && n < 10);
        req_exit = 0;
        check(n == MIN_DWELL, "R6 low dwell", n, MIN_DWELL);
        check(cmd_out == 2'd1 && pwr_state == 3'd1, "R7 exit nop", int'(cmd_out), 1);
        check(rd_ready == 1, "R9 pd exit read ready", int'(rd_ready), 1);

        // R5 and R3
        for (int i = 0; i < 3; i++) tick("R5");
        bank_open = 0; busy = 1; req_pd = 1;
        for (int i = 0; i < 6; i++) tick("R5");
        check(cke == 1 && pwr_state == 3'd1, "R5 busy hold", int'(pwr_state), 1);
        busy = 0;
        tick("R3");
        req_pd = 0;
        check(cke == 0 && pwr_state == 3'd3, "R3 precharge pd", int'(pwr_state), 3);

        // R10: forced exit from power-down
        for (int i = 0; i < 3; i++) tick("R10");
        force_exit = 1;
        tick("R10");
        force_exit = 0;
        check(cke == 1 && pwr_state == 3'd1, "R10 force exit pd", int'(pwr_state), 1);

        // R11: self refresh with an open bank
        for (int i = 0; i < 3; i++) tick("R11");
        bank_open = 1; req_sr = 1;
        tick("R11");
        req_sr = 0;
        check(illegal_req == 1 && cke == 1 && pwr_state == 3'd1, "R11 sr bank open",
              int'(illegal_req), 1);
        for (int i = 0; i < 4; i++) tick("R11");
        check(illegal_req == 1 && cke == 1, "R11 sticky", int'(illegal_req), 1);

        // R4, R10, R8, R9: self refresh path from a clean reset
        do_reset();
        for (int i = 0; i < 3; i++) tick("R4");
        bank_open = 0; req_sr = 1;
        tick("R4");
        req_sr = 0;
        check(cmd_out == 2'd2 && pwr_state == 3'd4 && cke == 0, "R4 sr entry", int'(cmd_out), 2);
        force_exit = 1;
        for (int i = 0; i < 5; i++) tick("R10");
        force_exit = 0;
        check(cke == 0 && pwr_state == 3'd4, "R10 force ignored in sr", int'(pwr_state), 4);
        req_exit = 1;
        tick("R7");
        req_exit = 0;
        check(cke == 1 && cmd_out == 2'd1, "R7 sr exit nop", int'(cmd_out), 1);
        n = 0;
        while (!cmd_ready && n < 50) begin
            check(cmd_out == 2'd1, "R8 nop during exit", int'(cmd_out), 1);
            tick("R8"); n++;
        end
        check(n == T_XSNR, "R8 non-read interval", n, T_XSNR);
        check(cmd_out == 2'd3, "R8 pass after interval", int'(cmd_out), 3);
        n = T_XSNR;
        while (!rd_ready && n < 400) begin tick("R9"); n++; end
        check(n == T_XSRD, "R9 read interval", n, T_XSRD);

        // R11: exit in normal state and entry in low state
        check(illegal_req == 0, "R11 clear after reset", int'(illegal_req), 0);
        req_exit = 1;
        tick("R11");
        req_exit = 0;
        check(illegal_req == 1 && cke == 1, "R11 exit in normal", int'(illegal_req), 1);
        do_reset();
        for (int i = 0; i < 3; i++) tick("R11");
        req_pd = 1;
        tick("R11");
        req_pd = 0;
        for (int i = 0; i < 3; i++) tick("R11");
        req_exit = 1; req_pd = 1;
        tick("R11");
        clear_reqs();
        check(illegal_req == 1 && cke == 0 && pwr_state == 3'd3, "R11 entry while low",
              int'(pwr_state), 3);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 100);
            req_pd     = (r < 8);
            req_sr     = (r >= 8 && r < 12);
            req_exit   = (r >= 12 && r < 22);
            force_exit = ($urandom % 20 == 0);
            bank_open  = ($urandom % 2 == 0);
            busy       = ($urandom % 4 == 0);
            rst        = ($urandom % 700 == 0);
            init_done  = ($urandom % 3 == 0);
            tick("R6");
        end
        rst = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule